// File: doc/BRIEF.md
# Fractional Phase-Shift Rate Controller

This block nudges the average frequency of a clock by sending fine phase-shift steps to the dynamic phase-shift port of a clock-management tile. It runs in the clock domain that is being shifted. An accumulator adds a programmable numerator every enabled cycle. Each time the sum reaches the programmable denominator, the denominator is subtracted and one step comes due. The average step rate is therefore exactly numerator/denominator steps per cycle. Consider a generated clock that runs slightly slow and must gain one full period every 51799 periods, where one period holds 1197 shift units. For that clock the block is set to 1197/51799 and advances the clock. This removes the need to switch between two clocks.

Each step is a one-cycle request followed by an acknowledge from the tile. If steps come due while a request is still unacknowledged, they wait in a small saturating queue and are not lost. A sticky flag records any saturation of that queue. A 32-bit counter reports how many steps the tile has acknowledged. The ratio and the direction are captured only while the block is disabled. Disabling the block also clears the pacing state.

Top module: `frac_step_pacer`

## Requirements
- R1: After a synchronous active-high reset, `ps_req` is 0, `steps_done` is 0 and `queue_ovf` is 0.
- R2: `rate_num` and `rate_den` are captured on every clock while `enable` is 0. Changes to them while `enable` is 1 have no effect on pacing.
- R3: While `enable` is 1 with 0 <= `rate_num` < `rate_den`, the number of steps that come due over T enabled cycles is exactly floor(T·num/den), counted from a cleared accumulator. With `rate_num` = 0, no step ever comes due.
- R4: `ps_req` is never high on two consecutive cycles.
- R5: After a request, no new request is issued until `ps_done` has been seen for that request. A `ps_done` with no request outstanding is ignored and does not change `steps_done`.
- R6: Steps that come due while a request is outstanding are queued in a saturating counter of `PEND_W` bits (default 4, maximum 15). A step that comes due while the queue is full sets `queue_ovf`, which stays 1 until reset.
- R7: `steps_done` increments by exactly one for each `ps_done` that acknowledges an outstanding request.
- R8: While `enable` is 0, the accumulator and the queue are cleared and no new request is issued. A request already outstanding still completes and is counted.
- R9: `ps_incdec` reflects `dir_advance` as it was captured while `enable` was 0. The value 1 means increment, which shortens the period. Changes to `dir_advance` while `enable` is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shifted clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run pacing; low to load settings and clear state |
| rate_num | input | 16 | Phase units added per cycle |
| rate_den | input | 16 | Accumulator threshold (cycles scale) |
| dir_advance | input | 1 | Step direction, 1 = increment |
| ps_req | output | 1 | One-cycle phase-step request to the tile |
| ps_incdec | output | 1 | Increment/decrement select to the tile |
| ps_done | input | 1 | Step-done acknowledge from the tile |
| steps_done | output | 32 | Count of acknowledged steps |
| queue_ovf | output | 1 | Sticky queue saturation flag |

## Verification
Some properties are checked by assertions on every cycle: the request is a single pulse, no request is issued while one is outstanding, the accumulator stays below the denominator, the queue and accumulator clear when the block is disabled, saturation raises the sticky flag, and each acknowledge adds exactly one to the counter. Other behaviour can only be shown by the bench's scenarios. These include the exact long-run step total for several ratios and tile latencies, the freezing of the ratio and direction while enabled, the ignoring of stray acknowledges, and overflow under a fast ratio with a slow tile.

// File: rtl/frac_pace_pkg.sv
package frac_pace_pkg;
  typedef enum logic {HS_IDLE = 1'b0, HS_WAIT = 1'b1} hs_state_t;
endpackage

// File: rtl/frac_pace_accum.sv
module frac_pace_accum #(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [RATIO_W-1:0] rate_num,
  input  logic [RATIO_W-1:0] rate_den,
  output logic               due
);
  localparam int SUM_W = RATIO_W + 1;

  logic [RATIO_W-1:0] num_q, den_q, acc_q;
  logic [SUM_W-1:0]   sum;
  logic               hit;

  assign sum = {1'b0, acc_q} + {1'b0, num_q};
  assign hit = enable && (den_q != '0) && (sum >= {1'b0, den_q});
  assign due = hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q <= '0;
      den_q <= '0;
      acc_q <= '0;
    end else if (!enable) begin
      num_q <= rate_num;
      den_q <= rate_den;
      acc_q <= '0;
    end else if (hit) begin
      acc_q <= RATIO_W'(sum - {1'b0, den_q});
    end else begin
      acc_q <= sum[RATIO_W-1:0];
    end
  end

  // R3: with a valid ratio the remainder never reaches the threshold
  a_r3_acc_below_den: assert property (@(posedge clk) disable iff (rst)
    (enable && num_q < den_q) |-> (acc_q < den_q));
  // R8: disabling clears the remainder
  a_r8_acc_cleared: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (acc_q == '0));
  // R2: captured ratio holds while enabled
  a_r2_ratio_frozen: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable)) |-> ($stable(num_q) && $stable(den_q)));
endmodule

// File: rtl/frac_pace_queue.sv
module frac_pace_queue
  import frac_pace_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic due,
  input  logic ps_done,
  output logic ps_req,
  output logic done_evt,
  output logic queue_ovf
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  hs_state_t         st_q;
  logic [PEND_W-1:0] pend_q;
  logic              req_q, ovf_q;
  logic              launch, inc, dec, have_pend;

  assign have_pend = (pend_q != '0);
  assign launch    = enable && (st_q == HS_IDLE) && (due || have_pend);
  assign dec       = launch && have_pend;
  assign inc       = due && !(launch && !have_pend);
  assign done_evt  = (st_q == HS_WAIT) && ps_done;
  assign ps_req    = req_q;
  assign queue_ovf = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= HS_IDLE;
      pend_q <= '0;
      req_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      req_q <= launch;
      if (launch)        st_q <= HS_WAIT;
      else if (done_evt) st_q <= HS_IDLE;
      if (!enable) begin
        pend_q <= '0;
      end else if (inc && !dec) begin
        if (pend_q == PEND_MAX) ovf_q <= 1'b1;
        else                    pend_q <= pend_q + 1'b1;
      end else if (dec && !inc) begin
        pend_q <= pend_q - 1'b1;
      end
    end
  end

  // R4: request is a single-cycle pulse
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
    ps_req |=> !ps_req);
  // R5: nothing new while the previous step is unacknowledged
  a_r5_no_req_busy: assert property (@(posedge clk) disable iff (rst)
    (st_q == HS_WAIT && !ps_done) |=> !ps_req);
  // R6: a due step on a full queue marks overflow
  a_r6_sat_flag: assert property (@(posedge clk) disable iff (rst)
    (enable && pend_q == PEND_MAX && inc && !dec) |=> queue_ovf);
  // R6: overflow is sticky
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    queue_ovf |=> queue_ovf);
  // R8: disabling empties the queue and blocks new requests
  a_r8_queue_cleared: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (pend_q == '0 && !ps_req));
endmodule

// File: rtl/frac_pace_tally.sv
module frac_pace_tally #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_evt,
  output logic [CNT_W-1:0] steps_done
);
  logic [CNT_W-1:0] cnt_q;
  assign steps_done = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (done_evt) cnt_q <= cnt_q + 1'b1;
  end

  // R7: one count per acknowledged step
  a_r7_count_step: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> (steps_done == $past(steps_done) + 1'b1));
  a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
    !done_evt |=> $stable(steps_done));
endmodule

// File: rtl/frac_step_pacer.sv
module frac_step_pacer #(
  parameter int RATIO_W = 16,
  parameter int PEND_W  = 4,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [RATIO_W-1:0] rate_num,
  input  logic [RATIO_W-1:0] rate_den,
  input  logic               dir_advance,
  output logic               ps_req,
  output logic               ps_incdec,
  input  logic               ps_done,
  output logic [CNT_W-1:0]   steps_done,
  output logic               queue_ovf
);
  logic due, done_evt, dir_q;

  always_ff @(posedge clk) begin
    if (rst)          dir_q <= 1'b1;
    else if (!enable) dir_q <= dir_advance;
  end
  assign ps_incdec = dir_q;

  frac_pace_accum #(.RATIO_W(RATIO_W)) u_accum (
    .clk(clk), .rst(rst), .enable(enable),
    .rate_num(rate_num), .rate_den(rate_den), .due(due)
  );

  frac_pace_queue #(.PEND_W(PEND_W)) u_queue (
    .clk(clk), .rst(rst), .enable(enable), .due(due), .ps_done(ps_done),
    .ps_req(ps_req), .done_evt(done_evt), .queue_ovf(queue_ovf)
  );

  frac_pace_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst(rst), .done_evt(done_evt), .steps_done(steps_done)
  );

  // R9: direction frozen while enabled
  a_r9_dir_frozen: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable)) |-> $stable(ps_incdec));
endmodule

// File: tb/frac_step_pacer_bench.sv
module frac_step_pacer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [15:0] rate_num = '0, rate_den = '0;
  logic        dir_advance = 1'b1;
  logic        ps_req, ps_incdec, queue_ovf;
  logic        ps_done = 1'b0;
  logic [31:0] steps_done;

  int checks = 0, failures = 0;
  int lat = 1;
  int cd = -1;
  bit outstanding = 0;
  bit manual_done = 0;
  int proto_err = 0;

  always #2 clk = ~clk;

  frac_step_pacer u_frac_step_pacer (
    .clk(clk), .rst(rst), .enable(enable), .rate_num(rate_num),
    .rate_den(rate_den), .dir_advance(dir_advance), .ps_req(ps_req),
    .ps_incdec(ps_incdec), .ps_done(ps_done), .steps_done(steps_done),
    .queue_ovf(queue_ovf)
  );

  // tile model: acknowledge lat cycles after each request
  always @(negedge clk) begin
    if (!manual_done) begin
      ps_done <= 1'b0;
      if (cd > 0) cd <= cd - 1;
      else if (cd == 0) begin ps_done <= 1'b1; cd <= -1; outstanding <= 1'b0; end
      if (ps_req) begin
        if (outstanding) proto_err <= proto_err + 1;
        outstanding <= 1'b1;
        cd <= lat - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int NV = 5;
  localparam int V_NUM [NV] = '{1197, 1, 1, 2, 0};
  localparam int V_DEN [NV] = '{51799, 4, 5, 21, 10};
  localparam int V_CYC [NV] = '{51799, 400, 503, 1000, 300};
  localparam int V_LAT [NV] = '{3, 1, 2, 4, 1};

  initial begin
    #4000000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint exp, base, d;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    check(ps_req == 0 && steps_done == 0 && queue_ovf == 0, "R1", steps_done, 0);

    // R3 / R7 vector walk
    for (int i = 0; i < NV; i++) begin
      lat = V_LAT[i];
      rate_num = 16'(V_NUM[i]); rate_den = 16'(V_DEN[i]);
      cyc(2);
      base = steps_done;
      enable = 1'b1;
      cyc(V_CYC[i]);
      enable = 1'b0;
      cyc(12);
      exp = (longint'(V_CYC[i]) * V_NUM[i]) / V_DEN[i];
      d = steps_done - base;
      check(d <= exp && d + 1 >= exp, "R3 R7 ratio total", d, exp);
    end
    check(proto_err == 0, "R4 R5 handshake", proto_err, 0);
    check(queue_ovf == 0, "R6 no overflow at slow rates", queue_ovf, 0);

    // R8 disabled: no steps
    base = steps_done;
    rate_num = 16'd1; rate_den = 16'd2;
    cyc(100);
    check(steps_done == base && ps_req == 0, "R8 idle when disabled", steps_done, base);

    // R5 stray acknowledge ignored
    manual_done = 1'b1;
    @(negedge clk) ps_done = 1'b1;
    @(negedge clk) ps_done = 1'b0;
    cyc(2);
    check(steps_done == base, "R5 stray done", steps_done, base);
    manual_done = 1'b0;

    // R2 ratio frozen while enabled, R9 direction frozen
    lat = 1;
    rate_num = 16'd1; rate_den = 16'd4; dir_advance = 1'b0;
    cyc(2);
    check(ps_incdec == 0, "R9 dir captured", ps_incdec, 0);
    base = steps_done;
    enable = 1'b1;
    cyc(1);
    rate_num = 16'd3; dir_advance = 1'b1;
    cyc(399);
    check(ps_incdec == 0, "R9 dir frozen", ps_incdec, 0);
    enable = 1'b0;
    cyc(12);
    d = steps_done - base;
    check(d <= 100 && d >= 99, "R2 ratio frozen", d, 100);
    cyc(2);
    check(ps_incdec == 1, "R9 dir reloaded", ps_incdec, 1);

    // R8 outstanding request completes after disable
    lat = 8;
    rate_num = 16'd1; rate_den = 16'd2;
    cyc(2);
    base = steps_done;
    enable = 1'b1;
    cyc(3);
    enable = 1'b0;
    cyc(15);
    check(steps_done == base + 1, "R8 outstanding completes", steps_done - base, 1);

    // R6 overflow with fast ratio and slow tile
    lat = 6;
    rate_num = 16'd9; rate_den = 16'd10;
    cyc(2);
    enable = 1'b1;
    cyc(200);
    check(queue_ovf == 1, "R6 overflow set", queue_ovf, 1);
    enable = 1'b0;
    cyc(20);
    check(queue_ovf == 1, "R6 overflow sticky", queue_ovf, 1);
    check(proto_err == 0, "R5 one outstanding under load", proto_err, 0);

    // R1 reset clears
    @(negedge clk) rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    check(steps_done == 0 && queue_ovf == 0 && ps_req == 0, "R1 re-reset", steps_done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule